// File: doc/BRIEF.md
# Command-Word Descriptor Address Generator

This block takes a 16-bit serial-bus command word that has already been checked upstream and arrives with a one-cycle valid strobe. It splits the word into four fields:

- terminal address
- transmit/receive direction
- subaddress
- word count or mode code

It then works out where the matching descriptor-table control word sits in shared memory. Each descriptor takes four consecutive words, and the control word is the first of the four.

Commands with subaddress 1 to 30 index the subaddress part of the table. Commands with subaddress 0 or 31 are mode-code commands. They are indexed by the low five bits taken as a mode code, in a separate region 0x100 words above the table base.

The host loads the table base through a write strobe, and the base resets to 0x0400. The descriptor address, a mode-code flag and a receive-subaddress flag are registered. They appear one clock after the valid strobe, together with a one-cycle output strobe, and hold their values until the next command.

Top module: `descAddrGen`

## Requirements
- R1: After reset, `descAddr` is 0x0000, `modeFlag`, `rxSubFlag` and `outStrobe` are 0, and the table base is 0x0400.
- R2: `outStrobe` is high for exactly the one cycle after each cycle in which `cmdValid` is high, and low otherwise.
- R3: For a command whose subaddress (bits 9:5) is 1 to 30, `descAddr` = base + (TR×32 + SA)×4, where TR is bit 10, and `modeFlag` is 0.
- R4: For a command whose subaddress is 0 or 31, `descAddr` = base + 0x100 + (TR×32 + MC)×4, where MC is bits 4:0, and `modeFlag` is 1.
- R5: `rxSubFlag` is 1 exactly when bit 10 is 0 and the subaddress is 1 to 30. It is never 1 together with `modeFlag`.
- R6: The terminal-address field (bits 15:11) has no effect on any output.
- R7: A command presented in the same cycle as a base write uses the previous base. The new base applies from the next cycle on.
- R8: While no command is presented, `descAddr`, `modeFlag` and `rxSubFlag` hold their last values.
- R9: The address sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Strobe: `cmdWord` holds a validated command |
| cmdWord | input | 16 | Received command word |
| baseWe | input | 1 | Host write strobe for the table base |
| baseIn | input | 16 | New table base value |
| descAddr | output | 16 | Address of the descriptor control word |
| modeFlag | output | 1 | Command is a mode-code command |
| rxSubFlag | output | 1 | Command is a receive subaddress command |
| outStrobe | output | 1 | Outputs updated this cycle |

## Verification
The two functions that can fall in the same cycle are the host's base write and the capture of a command word. The bench provokes this by raising `baseWe` and `cmdValid` on the same clock edge. It then expects the reported address to be built on the old base. A second command sent straight afterwards must show the new base. A checker keeps its own copy of the base and compares every captured address with it, so a design that forwards the incoming base is caught at that edge.

// File: rtl/descAddrPkg.sv
package descAddrPkg;
  typedef struct packed {
    logic [4:0] termAddr;
    logic       tr;
    logic [4:0] subAddr;
    logic [4:0] wcMc;
  } cmdFields_t;

  typedef struct packed {
    logic loadBase;
    logic captureCmd;
  } ctrlStrobes_t;

  function automatic logic isModeSa(input logic [4:0] sa);
    return (sa == 5'd0) || (sa == 5'd31);
  endfunction
endpackage

// File: rtl/descAddrCtrl.sv
module descAddrCtrl
  import descAddrPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         baseWe,
  output ctrlStrobes_t strobes,
  output logic         outStrobe
);
  always_comb begin
    strobes.loadBase   = baseWe;
    strobes.captureCmd = cmdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outStrobe <= 1'b0;
    else       outStrobe <= cmdValid;
  end
endmodule

// File: rtl/descAddrPath.sv
module descAddrPath
  import descAddrPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DESC_SHIFT  = 2,
  parameter logic [ADDR_W-1:0] MODE_REGION = 16'h0100,
  parameter logic [ADDR_W-1:0] BASE_RESET  = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [15:0]       cmdWord,
  input  logic [ADDR_W-1:0] baseIn,
  output logic [ADDR_W-1:0] descAddr,
  output logic              modeFlag,
  output logic              rxSubFlag
);
  localparam int IDX_W = 6;
  localparam int PAD_W = ADDR_W - IDX_W - DESC_SHIFT;

  cmdFields_t        fields;
  logic [ADDR_W-1:0] baseReg;
  logic              isMode;
  logic [IDX_W-1:0]  slotIdx;
  logic [ADDR_W-1:0] slotOfs;
  logic [ADDR_W-1:0] regionOfs;
  logic [ADDR_W-1:0] nextAddr;

  assign fields  = cmdFields_t'(cmdWord);
  assign isMode  = isModeSa(fields.subAddr);
  assign slotIdx = {fields.tr, isMode ? fields.wcMc : fields.subAddr};

  generate
    if (DESC_SHIFT == 0) begin : gNoShift
      assign slotOfs = {{PAD_W{1'b0}}, slotIdx};
    end else begin : gShift
      assign slotOfs = {{PAD_W{1'b0}}, slotIdx, {DESC_SHIFT{1'b0}}};
    end
  endgenerate

  assign regionOfs = isMode ? MODE_REGION : '0;
  assign nextAddr  = baseReg + regionOfs + slotOfs;

  always_ff @(posedge clk) begin
    if (!rstN) baseReg <= BASE_RESET;
    else if (strobes.loadBase) baseReg <= baseIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      modeFlag  <= 1'b0;
      rxSubFlag <= 1'b0;
    end else if (strobes.captureCmd) begin
      descAddr  <= nextAddr;
      modeFlag  <= isMode;
      rxSubFlag <= !fields.tr && !isMode;
    end
  end
endmodule

// File: rtl/descAddrGen.sv
module descAddrGen
  import descAddrPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DESC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [15:0]       cmdWord,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseIn,
  output logic [ADDR_W-1:0] descAddr,
  output logic              modeFlag,
  output logic              rxSubFlag,
  output logic              outStrobe
);
  ctrlStrobes_t strobes;

  descAddrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .baseWe(baseWe),
    .strobes(strobes), .outStrobe(outStrobe)
  );

  descAddrPath #(.ADDR_W(ADDR_W), .DESC_SHIFT(DESC_SHIFT)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdWord(cmdWord),
    .baseIn(baseIn), .descAddr(descAddr), .modeFlag(modeFlag),
    .rxSubFlag(rxSubFlag)
  );
endmodule

// File: rtl/descAddrChk.sv
module descAddrChk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [15:0] cmdWord,
  input logic        baseWe,
  input logic [15:0] baseIn,
  input logic [15:0] descAddr,
  input logic        modeFlag,
  input logic        rxSubFlag,
  input logic        outStrobe
);
  logic [15:0] shadowBase;
  logic [15:0] expAddr;
  logic        expMode;

  always_ff @(posedge clk) begin
    if (!rstN) shadowBase <= 16'h0400;
    else if (baseWe) shadowBase <= baseIn;
  end

  always_comb begin
    expMode = (cmdWord[9:5] == 5'd0) || (cmdWord[9:5] == 5'd31);
    if (expMode) expAddr = shadowBase + 16'h0100 + {8'd0, cmdWord[10], cmdWord[4:0], 2'b00};
    else         expAddr = shadowBase + {8'd0, cmdWord[10], cmdWord[9:5], 2'b00};
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> outStrobe); // R2
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !outStrobe); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ($stable(descAddr) && $stable(modeFlag) && $stable(rxSubFlag))); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(modeFlag && rxSubFlag)); // R5
  AST_MODE_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (modeFlag == $past(expMode))); // R4
  AST_ADDR_OLD_BASE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (descAddr == $past(expAddr))); // R7
endmodule

bind descAddrGen descAddrChk uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
  .baseWe(baseWe), .baseIn(baseIn), .descAddr(descAddr),
  .modeFlag(modeFlag), .rxSubFlag(rxSubFlag), .outStrobe(outStrobe)
);

// File: tb/sim_descAddrGen.sv
`timescale 1ns/1ps
module sim_descAddrGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic        baseWe = 1'b0;
  logic [15:0] baseIn = '0;
  logic [15:0] descAddr;
  logic        modeFlag, rxSubFlag, outStrobe;

  int checks = 0;
  int fails = 0;
  logic [15:0] curBase = 16'h0400;

  always #4 clk = ~clk;

  descAddrGen u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .baseWe(baseWe), .baseIn(baseIn), .descAddr(descAddr),
    .modeFlag(modeFlag), .rxSubFlag(rxSubFlag), .outStrobe(outStrobe)
  );

  function automatic logic [15:0] mkCmd(input logic [4:0] ta, input logic tr,
                                         input logic [4:0] sa, input logic [4:0] wc);
    return {ta, tr, sa, wc};
  endfunction

  function automatic logic [15:0] refAddr(input logic [15:0] b, input logic [15:0] w);
    int sa = int'(w[9:5]);
    int idx;
    if (sa == 0 || sa == 31) begin
      idx = int'(w[10]) * 32 + int'(w[4:0]);
      return 16'((int'(b) + 256 + idx * 4) % 65536);
    end
    idx = int'(w[10]) * 32 + sa;
    return 16'((int'(b) + idx * 4) % 65536);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic writeBase(input logic [15:0] b);
    @(negedge clk); baseWe = 1'b1; baseIn = b;
    @(negedge clk); baseWe = 1'b0;
    curBase = b;
  endtask

  task automatic sendCmd(input logic [15:0] w);
    @(negedge clk); cmdValid = 1'b1; cmdWord = w;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic checkCmd(input string req, input logic [15:0] w);
    logic mode;
    sendCmd(w);
    mode = (w[9:5] == 5'd0) || (w[9:5] == 5'd31);
    check({req, " addr"}, 32'(descAddr), 32'(refAddr(curBase, w)));
    check({req, " mode"}, 32'(modeFlag), 32'(mode));
    check({req, " rxsub"}, 32'(rxSubFlag), 32'(!w[10] && !mode));
    check({req, " strobe"}, 32'(outStrobe), 32'(1));
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 addr", 32'(descAddr), 32'h0);
    check("R1 mode", 32'(modeFlag), 32'h0);
    check("R1 rxsub", 32'(rxSubFlag), 32'h0);
    check("R1 strobe", 32'(outStrobe), 32'h0);
    sendCmd(mkCmd(5'd0, 1'b0, 5'd1, 5'd0));
    check("R1 base 0x0400", 32'(descAddr), 32'h0404);
  endtask

  task automatic testSubaddr();
    checkCmd("R3 rx sa1", mkCmd(5'd3, 1'b0, 5'd1, 5'd7));
    checkCmd("R3 tx sa15", mkCmd(5'd3, 1'b1, 5'd15, 5'd0));
    checkCmd("R5 rx sa30", mkCmd(5'd9, 1'b0, 5'd30, 5'd31));
    checkCmd("R3 tx sa30", mkCmd(5'd9, 1'b1, 5'd30, 5'd2));
  endtask

  task automatic testModeCode();
    checkCmd("R4 sa0 mc0 rx", mkCmd(5'd1, 1'b0, 5'd0, 5'd0));
    checkCmd("R4 sa31 mc31 tx", mkCmd(5'd1, 1'b1, 5'd31, 5'd31));
    checkCmd("R4 sa0 mc17 tx", mkCmd(5'd1, 1'b1, 5'd0, 5'd17));
    checkCmd("R5 sa31 rx", mkCmd(5'd1, 1'b0, 5'd31, 5'd2));
  endtask

  task automatic testTermAddrIgnored();
    logic [15:0] a0;
    sendCmd(mkCmd(5'd0, 1'b0, 5'd12, 5'd4));
    a0 = descAddr;
    sendCmd(mkCmd(5'd31, 1'b0, 5'd12, 5'd4));
    check("R6 ta ignored addr", 32'(descAddr), 32'(a0));
    check("R6 ta ignored rxsub", 32'(rxSubFlag), 32'h1);
  endtask

  task automatic testSameCycleBase();
    logic [15:0] w = mkCmd(5'd2, 1'b0, 5'd5, 5'd0);
    @(negedge clk);
    baseWe = 1'b1; baseIn = 16'h2000; cmdValid = 1'b1; cmdWord = w;
    @(negedge clk);
    baseWe = 1'b0; cmdValid = 1'b0;
    check("R7 same-cycle old base", 32'(descAddr), 32'(refAddr(curBase, w)));
    curBase = 16'h2000;
    checkCmd("R7 new base next", w);
  endtask

  task automatic testHold();
    logic [15:0] a0 = descAddr;
    logic m0 = modeFlag;
    @(negedge clk); cmdWord = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    check("R8 hold addr", 32'(descAddr), 32'(a0));
    check("R8 hold mode", 32'(modeFlag), 32'(m0));
    check("R2 no strobe idle", 32'(outStrobe), 32'h0);
  endtask

  task automatic testBackToBack();
    logic [15:0] w1 = mkCmd(5'd4, 1'b1, 5'd3, 5'd0);
    logic [15:0] w2 = mkCmd(5'd4, 1'b0, 5'd31, 5'd9);
    @(negedge clk); cmdValid = 1'b1; cmdWord = w1;
    @(negedge clk); cmdWord = w2;
    check("R2 b2b first addr", 32'(descAddr), 32'(refAddr(curBase, w1)));
    check("R2 b2b first strobe", 32'(outStrobe), 32'h1);
    @(negedge clk); cmdValid = 1'b0;
    check("R2 b2b second addr", 32'(descAddr), 32'(refAddr(curBase, w2)));
    check("R2 b2b second strobe", 32'(outStrobe), 32'h1);
    @(negedge clk);
    check("R2 strobe drops", 32'(outStrobe), 32'h0);
  endtask

  task automatic testWrap();
    writeBase(16'hFFF0);
    checkCmd("R9 wrap mode", mkCmd(5'd0, 1'b1, 5'd31, 5'd31));
    checkCmd("R9 wrap sub", mkCmd(5'd0, 1'b0, 5'd10, 5'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSubaddr();
    testModeCode();
    testTermAddrIgnored();
    testSameCycleBase();
    testHold();
    testBackToBack();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule